// File: doc/BRIEF.md
# Condition Test and Counted-Loop Step Unit

This unit decides whether a conditional control-flow operation happens. It checks a 4-bit condition code against the four arithmetic flags: negative, zero, overflow and carry. The condition set covers equality tests, unsigned magnitude tests, signed magnitude tests and single-flag tests. The unit also has constant-true and constant-false codes.

The same decision drives three kinds of operation:

- **Branch:** the condition result becomes the taken signal.
- **Set-byte:** the condition result becomes an all-ones or all-zeros byte, ready to be written to a destination.
- **Counted loop:** this is a test-then-count step. When the condition already holds, the loop falls through. Otherwise the low half of a 32-bit counter register counts down by one, and the loop repeats until that half wraps to all ones.

The unit has one register stage. Each accepted request produces its results exactly one cycle later. The unit does not compute target addresses and does not fetch.

Top module: `cc_loop_unit`

## Requirements
- R1: While reset is asserted, and after it is released until the first request, `out_valid`, `cond_true`, `taken`, `fill_byte` and `count_out` are all zero.
- R2: A request with `in_valid` high yields `out_valid` high on the next cycle. A cycle with `in_valid` low yields `out_valid` low on the next cycle.
- R3: The simple and unsigned codes (`cond_sel` value: condition) are:
  - 0: always true
  - 1: always false
  - 2: C=0 and Z=0
  - 3: C=1 or Z=1
  - 4: C=0
  - 5: C=1
  - 6: Z=0
  - 7: Z=1
  - 8: V=0
  - 9: V=1
  - 10: N=0
  - 11: N=1
- R4: The signed codes (`cond_sel` value: condition) are:
  - 12: N equals V
  - 13: N differs from V
  - 14: N equals V and Z=0
  - 15: Z=1 or N differs from V
- R5: `fill_byte` is 8'hFF when the registered condition is true and 8'h00 when it is false, in every mode.
- R6: In loop mode (`mode`=2'b10), a false condition decrements `count_in[15:0]` by one, wrapping 16'h0000 to 16'hFFFF. `taken` is 1 unless the new low half equals 16'hFFFF.
- R7: In loop mode, a true condition leaves `count_out` equal to `count_in` and makes `taken` 0.
- R8: In branch mode (`mode`=2'b00 or 2'b11), `taken` equals the condition. In set-byte mode (`mode`=2'b01), `taken` is 0. In both branch and set-byte mode, `count_out` equals `count_in`.
- R9: `count_out[31:16]` always equals `count_in[31:16]` of the same request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| mode | input | 2 | 00 branch, 01 set-byte, 10 loop, 11 branch |
| cond_sel | input | 4 | Condition code |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| count_in | input | 32 | Counter register value |
| out_valid | output | 1 | Result strobe |
| cond_true | output | 1 | Condition result |
| fill_byte | output | 8 | Set-byte value |
| count_out | output | 32 | Updated counter register |
| taken | output | 1 | Branch decision |

## Verification
The bench targets the loop counter at 0, 1 and 16'hFFFF:

- A design that exits when the count reaches zero, rather than on the wrap, would take the branch where it should fall through.
- A design that borrows into the upper half would break the pass-through check.

The signed codes are driven with every combination of N, V and Z. This exposes a greater-than or less-or-equal code that ignores Z, or swaps the equal and differ tests. Loop requests with a true condition catch a design that decrements anyway.

// File: rtl/cc_pkg.sv
package cc_pkg;

  typedef enum logic [1:0] {
    MODE_BRANCH = 2'b00,
    MODE_SET    = 2'b01,
    MODE_LOOP   = 2'b10,
    MODE_ALT    = 2'b11
  } cc_mode_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } cc_flags_t;

  // Condition code decode; the code order is visible to software.
  function automatic logic cc_eval(input logic [3:0] sel, input cc_flags_t f);
    logic nv_same;
    logic r;
    nv_same = ~(f.n ^ f.v);
    unique case (sel)
      4'd0:  r = 1'b1;
      4'd1:  r = 1'b0;
      4'd2:  r = ~f.c & ~f.z;
      4'd3:  r = f.c | f.z;
      4'd4:  r = ~f.c;
      4'd5:  r = f.c;
      4'd6:  r = ~f.z;
      4'd7:  r = f.z;
      4'd8:  r = ~f.v;
      4'd9:  r = f.v;
      4'd10: r = ~f.n;
      4'd11: r = f.n;
      4'd12: r = nv_same;
      4'd13: r = ~nv_same;
      4'd14: r = nv_same & ~f.z;
      4'd15: r = f.z | ~nv_same;
      default: r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cc_cond_eval.sv
module cc_cond_eval
  import cc_pkg::*;
(
  input  logic [3:0] sel,
  input  cc_flags_t  flags,
  output logic       cond,
  output logic       signed_cls
);
  // Codes 12..15 form the signed class.
  assign signed_cls = sel[3] & sel[2];
  assign cond       = cc_eval(sel, flags);
endmodule

// File: rtl/cc_loop_step.sv
module cc_loop_step
  import cc_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int LOOP_W = 16
) (
  input  cc_mode_e           mode,
  input  logic               cond,
  input  logic [CNT_W-1:0]   cnt_in,
  output logic [CNT_W-1:0]   cnt_nxt,
  output logic               take_nxt,
  output logic               wrap_exit
);
  localparam int UPPER_W = CNT_W - LOOP_W;

  logic [LOOP_W-1:0] low_dec;
  logic              do_dec;

  assign do_dec  = (mode == MODE_LOOP) && !cond;
  assign low_dec = cnt_in[LOOP_W-1:0] - LOOP_W'(1);
  assign wrap_exit = do_dec && (low_dec == {LOOP_W{1'b1}});

  assign cnt_nxt[LOOP_W-1:0] = do_dec ? low_dec : cnt_in[LOOP_W-1:0];

  generate
    if (UPPER_W > 0) begin : g_upper
      assign cnt_nxt[CNT_W-1:LOOP_W] = cnt_in[CNT_W-1:LOOP_W];
    end
  endgenerate

  always_comb begin
    unique case (mode)
      MODE_SET:  take_nxt = 1'b0;
      MODE_LOOP: take_nxt = do_dec && !wrap_exit;
      default:   take_nxt = cond;
    endcase
  end
endmodule

// File: rtl/cc_loop_unit.sv
module cc_loop_unit
  import cc_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int LOOP_W = 16,
  parameter int FILL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        mode,
  input  logic [3:0]        cond_sel,
  input  logic              flag_n,
  input  logic              flag_z,
  input  logic              flag_v,
  input  logic              flag_c,
  input  logic [CNT_W-1:0]  count_in,
  output logic              out_valid,
  output logic              cond_true,
  output logic [FILL_W-1:0] fill_byte,
  output logic [CNT_W-1:0]  count_out,
  output logic              taken
);
  cc_flags_t        flags_w;
  cc_mode_e         mode_w;
  logic             cond_now;
  logic             signed_cls;
  logic [CNT_W-1:0] cnt_nxt;
  logic             take_nxt;
  logic             wrap_exit;

  assign flags_w = '{n: flag_n, z: flag_z, v: flag_v, c: flag_c};
  assign mode_w  = cc_mode_e'(mode);

  cc_cond_eval u_eval (
    .sel        (cond_sel),
    .flags      (flags_w),
    .cond       (cond_now),
    .signed_cls (signed_cls)
  );

  cc_loop_step #(.CNT_W(CNT_W), .LOOP_W(LOOP_W)) u_step (
    .mode      (mode_w),
    .cond      (cond_now),
    .cnt_in    (count_in),
    .cnt_nxt   (cnt_nxt),
    .take_nxt  (take_nxt),
    .wrap_exit (wrap_exit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      cond_true <= 1'b0;
      fill_byte <= '0;
      count_out <= '0;
      taken     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        cond_true <= cond_now;
        fill_byte <= {FILL_W{cond_now}};
        count_out <= cnt_nxt;
        taken     <= take_nxt;
      end
    end
  end
endmodule

// File: rtl/cc_loop_chk.sv
module cc_loop_chk #(
  parameter int CNT_W  = 32,
  parameter int LOOP_W = 16,
  parameter int FILL_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        mode,
  input logic              cond_now,
  input logic              wrap_exit,
  input logic [CNT_W-1:0]  count_in,
  input logic              out_valid,
  input logic              cond_true,
  input logic [FILL_W-1:0] fill_byte,
  input logic [CNT_W-1:0]  count_out,
  input logic              taken
);
  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_fill_cond_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (fill_byte == {FILL_W{cond_true}}));
  p_loop_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b10 && !cond_now) |=> (taken == !$past(wrap_exit)));
  p_loop_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b10 && cond_now) |=> (!taken && count_out == $past(count_in)));
  p_set_no_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b01) |=> !taken);
  p_upper_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (count_out[CNT_W-1:LOOP_W] == $past(count_in[CNT_W-1:LOOP_W])));
endmodule

bind cc_loop_unit cc_loop_chk #(.CNT_W(CNT_W), .LOOP_W(LOOP_W), .FILL_W(FILL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .mode      (mode),
  .cond_now  (cond_now),
  .wrap_exit (wrap_exit),
  .count_in  (count_in),
  .out_valid (out_valid),
  .cond_true (cond_true),
  .fill_byte (fill_byte),
  .count_out (count_out),
  .taken     (taken)
);

// File: tb/sim_cc_loop_unit.sv
`timescale 1ns/1ps
module sim_cc_loop_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  mode;
  logic [3:0]  cond_sel;
  logic        fn, fz, fv, fc;
  logic [31:0] count_in;
  logic        out_valid, cond_true, taken;
  logic [7:0]  fill_byte;
  logic [31:0] count_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cc_loop_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .cond_sel(cond_sel), .flag_n(fn), .flag_z(fz), .flag_v(fv), .flag_c(fc),
    .count_in(count_in), .out_valid(out_valid), .cond_true(cond_true),
    .fill_byte(fill_byte), .count_out(count_out), .taken(taken)
  );

  // Reference condition (R3, R4), written as a flag-lookup table.
  function automatic bit ref_cond(input logic [3:0] s, input bit n, z, v, c);
    bit lt;
    lt = (n != v);
    if (s == 0) return 1;
    if (s == 1) return 0;
    if (s == 2) return !(c || z);
    if (s == 3) return c || z;
    if (s == 4) return c == 0;
    if (s == 5) return c == 1;
    if (s == 6) return z == 0;
    if (s == 7) return z == 1;
    if (s == 8) return v == 0;
    if (s == 9) return v == 1;
    if (s == 10) return n == 0;
    if (s == 11) return n == 1;
    if (s == 12) return !lt;
    if (s == 13) return lt;
    if (s == 14) return !lt && !z;
    return lt || z;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one request on a falling edge, check results on the next falling edge.
  task automatic run(input logic [1:0] m, input logic [3:0] s, input bit n, z, v, c,
                     input logic [31:0] cnt);
    bit e_cond, e_take;
    logic [31:0] e_cnt;
    logic [15:0] lo;
    @(negedge clk);
    in_valid = 1; mode = m; cond_sel = s; fn = n; fz = z; fv = v; fc = c; count_in = cnt;
    e_cond = ref_cond(s, n, z, v, c);
    e_cnt = cnt; e_take = 0;
    if (m == 2'b10) begin
      if (!e_cond) begin
        lo = cnt[15:0] + 16'hFFFF;
        e_cnt = {cnt[31:16], lo};
        e_take = (lo != 16'hFFFF);
      end
    end else if (m != 2'b01) begin
      e_take = e_cond;
    end
    @(negedge clk);
    in_valid = 0;
    chk("R2 out_valid", 64'(out_valid), 64'd1);
    chk((s >= 12) ? "R4 cond" : "R3 cond", 64'(cond_true), 64'(e_cond));
    chk("R5 fill", 64'(fill_byte), e_cond ? 64'hFF : 64'h00);
    chk(m == 2'b10 ? (e_cond ? "R7 count" : "R6 count") : "R8 count", 64'(count_out), 64'(e_cnt));
    chk(m == 2'b10 ? (e_cond ? "R7 taken" : "R6 taken") : "R8 taken", 64'(taken), 64'(e_take));
    chk("R9 upper", 64'(count_out[31:16]), 64'(cnt[31:16]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; in_valid = 0; mode = 0; cond_sel = 0;
    fn = 0; fz = 0; fv = 0; fc = 0; count_in = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    chk("R1 reset", {out_valid, cond_true, taken, fill_byte, count_out}, 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 post-reset idle", {out_valid, cond_true, taken, fill_byte, count_out}, 64'd0);

    // R6 loop boundaries, condition forced false with code 1
    run(2'b10, 4'd1, 0, 0, 0, 0, 32'hA5A5_0000);
    run(2'b10, 4'd1, 0, 0, 0, 0, 32'h1234_0001);
    run(2'b10, 4'd1, 0, 0, 0, 0, 32'h0F0F_FFFF);
    // R7 true condition holds the counter
    run(2'b10, 4'd0, 0, 0, 0, 0, 32'h0000_0000);
    // R4 exhaustive signed codes over N, Z, V
    for (int s = 12; s < 16; s++)
      for (int f = 0; f < 8; f++)
        run(2'b00, 4'(s), f[2], f[1], f[0], 0, 32'h0);
    // R3 every simple code over all flags, set-byte mode
    for (int s = 0; s < 12; s++)
      for (int f = 0; f < 16; f++)
        run(2'b01, 4'(s), f[3], f[2], f[1], f[0], 32'h5555_AAAA);
    // R8 alternate branch encoding
    run(2'b11, 4'd7, 0, 1, 0, 0, 32'h1);

    // R2 idle cycle gives no output strobe
    @(negedge clk);
    chk("R2 idle", 64'(out_valid), 64'd0);

    for (int i = 0; i < 1500; i++) begin
      logic [31:0] r;
      logic [31:0] cnt;
      r = $urandom;
      cnt = $urandom;
      if (r[12:11] == 0) cnt[15:0] = 16'(r[13] ? 1 : 0);
      run(r[1:0], r[5:2], r[6], r[7], r[8], r[9], cnt);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule